// File: doc/BRIEF.md
# Write-Protect Command Sequence Guard

This block sits between a host write port and the page-write sequencer of a non-volatile memory. It inspects every accepted write, which is an address and a data byte. It looks for two fixed command patterns. The enable pattern is three writes long. It turns on a sticky protection flag and also opens a key window. Data writes inside that window are committed. The disable pattern is six writes long and turns the flag off. Bytes that belong to a command pattern are consumed by the guard and never reach the sequencer. The addresses the patterns use stay normal storage locations for any other data.

Every other write is passed downstream with a commit-enable bit. While protection is off, every data write commits. While protection is on, a data write commits only inside the key window. Otherwise it is still handed to the sequencer with commit-enable low, so the sequencer runs its timed busy cycle but stores nothing. The byte-load timer of the sequencer drives `seq_timeout`. Each pulse returns both pattern matchers to idle and closes the key window.

Back-pressure rules: the input stream `wr_*` and the output stream `cm_*` are valid/ready. The guard accepts a command byte at once, whatever the state of `cm_ready`. A data write is offered on `cm_*` in the same cycle and is accepted only when `cm_ready` is high. A write that is not accepted changes no state. All command values are parameters. In the defaults, step i is the i-th write:
- The enable pattern is AA@05555, 55@02AAA, A0@05555.
- The disable pattern is AA@05555, 55@02AAA, 80@05555, AA@05555, 55@02AAA, 20@05555.

Top module: `wpg_guard`

## Requirements
- R1: After reset `prot` is 0, and a data write is forwarded on `cm_*` with `cm_commit` = 1.
- R2: Three accepted writes that match the enable pattern in order set `prot` to 1 after the third one. None of the three raises `cm_valid`.
- R3: After a completed enable pattern, each data write is forwarded with `cm_commit` = 1 until the next `seq_timeout` pulse.
- R4: While `prot` = 1 and no key window is open, a data write is still forwarded, but with `cm_commit` = 0.
- R5: Six accepted writes that match the disable pattern clear `prot`. None of the six raises `cm_valid`, and the next data write commits.
- R6: A write that does not match the next expected step resets the matcher to idle and is treated as data. If that write equals step 0 of a pattern, it is consumed as a fresh step 0 instead.
- R7: A write to a pattern address whose data does not match the pattern is an ordinary data write.
- R8: A `seq_timeout` pulse between pattern steps abandons the partial match, so the remaining steps are then treated as data.
- R9: A command byte is accepted (`wr_ready` = 1) even while `cm_ready` = 0. A data write waits for `cm_ready`, and a data write that is not accepted does not break a pattern in progress.
- R10: `prot` changes only when an accepted write completes a pattern. Data writes and timeouts leave it unchanged.
- R11: A write presented in the same cycle as `seq_timeout` is evaluated from the idle matcher state with the key window closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write offered |
| wr_ready | output | 1 | Host write accepted this cycle |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| seq_timeout | input | 1 | Byte-load window expired (one-cycle pulse) |
| cm_valid | output | 1 | Data write offered to the page sequencer |
| cm_ready | input | 1 | Page sequencer takes the write |
| cm_addr | output | AW | Forwarded address |
| cm_data | output | DW | Forwarded data |
| cm_commit | output | 1 | 1 = store the byte, 0 = run a dummy timed cycle |
| prot | output | 1 | Protection flag |

## Verification
The write streams contain unprotected writes, a complete enable pattern followed by keyed page bytes, unkeyed writes under protection, and the six-write disable pattern. Together these show how the flag and the key affect `cm_commit`. Broken patterns, a repeated step 0, and pattern addresses carrying other data separate a strict step matcher from one that restarts or one that matches on address alone. Timeouts placed between steps and in the same cycle as a write show whether the matcher and the key window are cleared before that write is evaluated. Running a pattern while `cm_ready` is low, with a stalled data write in the middle, shows that command bytes bypass back-pressure and that writes which are not accepted leave the state unchanged.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  typedef enum logic [1:0] {
    FLG_HOLD = 2'd0,
    FLG_SET  = 2'd1,
    FLG_CLR  = 2'd2
  } flg_act_t;
endpackage

// File: rtl/wpg_seq_match.sv
module wpg_seq_match #(
  parameter int AW  = 17,
  parameter int DW  = 8,
  parameter int LEN = 3,
  parameter logic [LEN*AW-1:0] PAT_A = '0,
  parameter logic [LEN*DW-1:0] PAT_D = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic          flush,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          consume,
  output logic          complete
);
  localparam int PW = $clog2(LEN + 1);

  logic [PW-1:0] pos_q, pos_eff, pos_nxt;
  logic          hit_cur, hit_first, at_last;

  always_comb begin
    pos_eff = clear ? '0 : pos_q;
    hit_cur = 1'b0;
    for (int i = 0; i < LEN; i++) begin
      if (pos_eff == PW'(i) && addr == PAT_A[i*AW +: AW] && data == PAT_D[i*DW +: DW])
        hit_cur = 1'b1;
    end
    hit_first = (addr == PAT_A[AW-1:0]) && (data == PAT_D[DW-1:0]);
    at_last   = (pos_eff == PW'(LEN - 1));
    complete  = hit_cur & at_last;
    consume   = hit_cur | hit_first;
    pos_nxt   = pos_eff;
    if (step) begin
      if (flush || complete) pos_nxt = '0;
      else if (hit_cur)      pos_nxt = pos_eff + 1'b1;
      else if (hit_first)    pos_nxt = PW'(1);
      else                   pos_nxt = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_nxt;
  end
endmodule

// File: rtl/wpg_flags.sv
module wpg_flags
  import wpg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  flg_act_t act,
  input  logic     timeout,
  output logic     prot_q,
  output logic     key_eff
);
  logic key_q;

  assign key_eff = timeout ? 1'b0 : key_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_q <= 1'b0;
      key_q  <= 1'b0;
    end else begin
      unique case (act)
        FLG_SET: begin prot_q <= 1'b1; key_q <= 1'b1;    end
        FLG_CLR: begin prot_q <= 1'b0; key_q <= 1'b0;    end
        default: begin prot_q <= prot_q; key_q <= key_eff; end
      endcase
    end
  end
endmodule

// File: rtl/wpg_guard.sv
module wpg_guard
  import wpg_pkg::*;
#(
  parameter int AW      = 17,
  parameter int DW      = 8,
  parameter int EN_LEN  = 3,
  parameter int DIS_LEN = 6,
  parameter logic [EN_LEN*AW-1:0]  EN_A  = {17'h05555, 17'h02AAA, 17'h05555},
  parameter logic [EN_LEN*DW-1:0]  EN_D  = {8'hA0, 8'h55, 8'hAA},
  parameter logic [DIS_LEN*AW-1:0] DIS_A = {17'h05555, 17'h02AAA, 17'h05555,
                                            17'h05555, 17'h02AAA, 17'h05555},
  parameter logic [DIS_LEN*DW-1:0] DIS_D = {8'h20, 8'h55, 8'hAA, 8'h80, 8'h55, 8'hAA}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          seq_timeout,
  output logic          cm_valid,
  input  logic          cm_ready,
  output logic [AW-1:0] cm_addr,
  output logic [DW-1:0] cm_data,
  output logic          cm_commit,
  output logic          prot
);
  logic     step, is_cmd;
  logic     en_consume, en_done, dis_consume, dis_done;
  logic     key_eff;
  flg_act_t act;

  assign is_cmd   = en_consume | dis_consume;
  assign wr_ready = is_cmd | cm_ready;
  assign step     = wr_valid & wr_ready;

  wpg_seq_match #(.AW(AW), .DW(DW), .LEN(EN_LEN), .PAT_A(EN_A), .PAT_D(EN_D)) u_en (
    .clk(clk), .rst_n(rst_n), .clear(seq_timeout), .step(step),
    .flush(dis_done), .addr(wr_addr), .data(wr_data),
    .consume(en_consume), .complete(en_done)
  );

  wpg_seq_match #(.AW(AW), .DW(DW), .LEN(DIS_LEN), .PAT_A(DIS_A), .PAT_D(DIS_D)) u_dis (
    .clk(clk), .rst_n(rst_n), .clear(seq_timeout), .step(step),
    .flush(en_done), .addr(wr_addr), .data(wr_data),
    .consume(dis_consume), .complete(dis_done)
  );

  always_comb begin
    act = FLG_HOLD;
    if (step && en_done)       act = FLG_SET;
    else if (step && dis_done) act = FLG_CLR;
  end

  wpg_flags u_flags (
    .clk(clk), .rst_n(rst_n), .act(act), .timeout(seq_timeout),
    .prot_q(prot), .key_eff(key_eff)
  );

  assign cm_valid  = wr_valid & ~is_cmd;
  assign cm_addr   = wr_addr;
  assign cm_data   = wr_data;
  assign cm_commit = ~prot | key_eff;
endmodule

// File: rtl/wpg_guard_chk.sv
module wpg_guard_chk #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          seq_timeout,
  input logic          cm_valid,
  input logic          cm_ready,
  input logic [AW-1:0] cm_addr,
  input logic [DW-1:0] cm_data,
  input logic          cm_commit,
  input logic          prot
);
  // R9
  stall_only_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |-> (cm_valid && !cm_ready));

  // R1
  unprot_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !prot) |-> cm_commit);

  // R11
  timeout_closes_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_timeout && prot && cm_valid) |-> !cm_commit);

  // R10
  prot_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_ready) |=> $stable(prot));

  // R10
  prot_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && cm_valid) |=> $stable(prot));
endmodule

bind wpg_guard wpg_guard_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/wpg_guard_bench.sv
module wpg_guard_bench;
  localparam int AW = 17;
  localparam int DW = 8;

  typedef struct packed {
    logic        wr;
    logic        to;
    logic [16:0] a;
    logic [7:0]  d;
    logic        cmv;
    logic        com;
    logic        prt;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,17'h00010,8'h12,1'b1,1'b1,1'b0,4'd1},  // R1 plain write
    '{1'b1,1'b0,17'h05555,8'hAA,1'b0,1'b0,1'b0,4'd2},  // R2 step 0
    '{1'b1,1'b0,17'h02AAA,8'h55,1'b0,1'b0,1'b0,4'd2},
    '{1'b1,1'b0,17'h05555,8'hA0,1'b0,1'b0,1'b1,4'd2},  // R2 done
    '{1'b1,1'b0,17'h00100,8'h11,1'b1,1'b1,1'b1,4'd3},  // R3 keyed
    '{1'b1,1'b0,17'h00101,8'h22,1'b1,1'b1,1'b1,4'd3},
    '{1'b1,1'b1,17'h00102,8'h33,1'b1,1'b0,1'b1,4'd11}, // R11
    '{1'b1,1'b0,17'h00103,8'h44,1'b1,1'b0,1'b1,4'd4},  // R4
    '{1'b1,1'b0,17'h05555,8'h12,1'b1,1'b0,1'b1,4'd7},  // R7
    '{1'b1,1'b0,17'h05555,8'hAA,1'b0,1'b0,1'b1,4'd6},
    '{1'b1,1'b0,17'h00200,8'h01,1'b1,1'b0,1'b1,4'd6},  // R6 break
    '{1'b1,1'b0,17'h05555,8'hAA,1'b0,1'b0,1'b1,4'd6},
    '{1'b1,1'b0,17'h05555,8'hAA,1'b0,1'b0,1'b1,4'd6},  // R6 restart
    '{1'b1,1'b0,17'h02AAA,8'h55,1'b0,1'b0,1'b1,4'd6},
    '{1'b1,1'b0,17'h05555,8'hA0,1'b0,1'b0,1'b1,4'd6},
    '{1'b1,1'b0,17'h00300,8'h5A,1'b1,1'b1,1'b1,4'd6},
    '{1'b0,1'b1,17'h00000,8'h00,1'b0,1'b0,1'b1,4'd10}, // R10 timeout only
    '{1'b1,1'b0,17'h05555,8'hAA,1'b0,1'b0,1'b1,4'd8},
    '{1'b1,1'b0,17'h02AAA,8'h55,1'b0,1'b0,1'b1,4'd8},
    '{1'b0,1'b1,17'h00000,8'h00,1'b0,1'b0,1'b1,4'd8},
    '{1'b1,1'b0,17'h05555,8'hA0,1'b1,1'b0,1'b1,4'd8},  // R8
    '{1'b1,1'b0,17'h05555,8'hAA,1'b0,1'b0,1'b1,4'd5},
    '{1'b1,1'b0,17'h02AAA,8'h55,1'b0,1'b0,1'b1,4'd5},
    '{1'b1,1'b0,17'h05555,8'h80,1'b0,1'b0,1'b1,4'd5},
    '{1'b1,1'b0,17'h05555,8'hAA,1'b0,1'b0,1'b1,4'd5},
    '{1'b1,1'b0,17'h02AAA,8'h55,1'b0,1'b0,1'b1,4'd5},
    '{1'b1,1'b0,17'h05555,8'h20,1'b0,1'b0,1'b0,4'd5},  // R5 done
    '{1'b1,1'b0,17'h00400,8'h77,1'b1,1'b1,1'b0,4'd5},
    '{1'b1,1'b0,17'h05555,8'hAA,1'b0,1'b0,1'b0,4'd2},
    '{1'b1,1'b0,17'h02AAA,8'h55,1'b0,1'b0,1'b0,4'd2},
    '{1'b1,1'b0,17'h05555,8'hA0,1'b0,1'b0,1'b1,4'd2}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_valid, wr_ready, seq_timeout, cm_valid, cm_ready, cm_commit, prot;
  logic [AW-1:0] wr_addr, cm_addr;
  logic [DW-1:0] wr_data, cm_data;
  int            n_chk = 0;
  int            n_bad = 0;

  always #2.5 clk = ~clk;

  wpg_guard u_wpg_guard (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .seq_timeout(seq_timeout),
    .cm_valid(cm_valid), .cm_ready(cm_ready), .cm_addr(cm_addr),
    .cm_data(cm_data), .cm_commit(cm_commit), .prot(prot)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic v, input logic to, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic rdy);
    @(negedge clk);
    wr_valid = v; seq_timeout = to; wr_addr = a; wr_data = d; cm_ready = rdy;
    #1;
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; seq_timeout = 1'b0; wr_addr = '0; wr_data = '0; cm_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1", "prot after reset", 32'(prot), 32'd0);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[i].rq);
      put(VEC[i].wr, VEC[i].to, VEC[i].a, VEC[i].d, 1'b1);
      chk(rq, $sformatf("vec %0d cm_valid", i), 32'(cm_valid), 32'(VEC[i].cmv));
      if (VEC[i].cmv) begin
        chk(rq, $sformatf("vec %0d cm_commit", i), 32'(cm_commit), 32'(VEC[i].com));
        chk(rq, $sformatf("vec %0d cm_addr", i), 32'(cm_addr), 32'(VEC[i].a));
      end
      after_edge();
      chk(rq, $sformatf("vec %0d prot", i), 32'(prot), 32'(VEC[i].prt));
    end

    // R9: disable pattern with the sequencer stalled, a stalled data write in the middle
    put(1'b1, 1'b0, 17'h05555, 8'hAA, 1'b0);
    chk("R9", "cmd ready while stalled", 32'(wr_ready), 32'd1);
    chk("R9", "cmd not forwarded", 32'(cm_valid), 32'd0);
    after_edge();
    put(1'b1, 1'b0, 17'h00500, 8'h99, 1'b0);
    chk("R9", "data waits", 32'(wr_ready), 32'd0);
    chk("R9", "data offered", 32'(cm_valid), 32'd1);
    after_edge();
    put(1'b1, 1'b0, 17'h02AAA, 8'h55, 1'b0); after_edge();
    put(1'b1, 1'b0, 17'h05555, 8'h80, 1'b0); after_edge();
    put(1'b1, 1'b0, 17'h05555, 8'hAA, 1'b0); after_edge();
    put(1'b1, 1'b0, 17'h02AAA, 8'h55, 1'b0); after_edge();
    chk("R9", "prot before last step", 32'(prot), 32'd1);
    put(1'b1, 1'b0, 17'h05555, 8'h20, 1'b0); after_edge();
    chk("R9", "stalled data kept pattern intact", 32'(prot), 32'd0);

    // R1: reset in mid operation returns to unprotected
    put(1'b1, 1'b0, 17'h05555, 8'hAA, 1'b1); after_edge();
    put(1'b1, 1'b0, 17'h02AAA, 8'h55, 1'b1); after_edge();
    put(1'b1, 1'b0, 17'h05555, 8'hA0, 1'b1); after_edge();
    chk("R2", "re-enabled", 32'(prot), 32'd1);
    @(negedge clk); rst_n = 1'b0; wr_valid = 1'b0;
    after_edge();
    @(negedge clk); rst_n = 1'b1;
    put(1'b1, 1'b0, 17'h00600, 8'h3C, 1'b1);
    chk("R1", "prot cleared by reset", 32'(prot), 32'd0);
    chk("R1", "commit after reset", 32'(cm_commit), 32'd1);
    after_edge();
    @(negedge clk); wr_valid = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule